// File: doc/BRIEF.md
# Split-Lane Stream Bus Master with Slave-to-Slave Bypass

This block is the only master on a streaming bus whose two lanes run in opposite directions. The write lane carries packets out to a daisy chain of slave kernels. The read lane brings packets back from them. Packets from the host arrive on an upstream stream port and go out on the write lane in the order they arrived. Packets that the slaves return are sent to the downstream stream port toward the host. A returning packet can also be looped straight back onto the write lane when it is addressed to another slave on the same bus.

Only one slave may use the read lane at a time. The master chooses that slave by driving an access token on the read lane's user sideband. The token names a slave ID and moves round-robin over the slave IDs. It stays on a slave until that slave finishes a packet, or until one slot of idle cycles has passed. A packet looped onto the write lane occupies both lanes at once, so the bus carries half as much traffic while such a packet is in flight. The bypass path is what lets one slave reach another, because the bus has only one master.

Top module: `stream_bus_master`

## Requirements
- R1: During and right after reset, wrValid and dnValid are low, and rdUser holds the lowest slave ID, FIRST_SLAVE (2 by default).
- R2: Each upstream packet appears on the write lane in the same cycle it is accepted from the upstream port. Its data, keep, last, id and dest are unchanged, packets keep their arrival order, and wrUser equals MASTER_ID (1 by default).
- R3: The two lanes work independently. A write-lane beat from upstream and a read-lane beat going to the downstream port can both be accepted in the same cycle.
- R4: rdUser carries the access token, which is a slave ID in FIRST_SLAVE to FIRST_SLAVE+NUM_SLAVES-1 (2 to 5 by default). A read-lane beat is valid only from the slave named by the token. The token moves to the next ID, wrapping from the highest to the lowest, in the cycle after that slave's tlast beat is accepted.
- R5: If the token holder does not present rdValid for SLOT_CYCLES consecutive cycles (4 by default), the token moves to the next ID. With no read traffic, every token value lasts exactly SLOT_CYCLES cycles.
- R6: The route of a read packet is set by the tdest of its first beat. If that tdest is a slave ID (2 to 5), the packet is sent onto the write lane. Each beat is accepted from the read lane in the same cycle it is accepted on the write lane, with identical fields, and wrUser equals the sending slave's ID.
- R7: A read packet whose first-beat tdest is MASTER_ID or any ID outside the slave range (0, 1 and 6 to 15 by default) is delivered unchanged on the downstream port. Packets from each slave keep their order.
- R8: After the first beat of a packet is accepted on a lane, no beat of any other packet is accepted on that lane until the packet's tlast beat is accepted. The route chosen at the first beat holds for the whole packet.
- R9: Any pattern of wrReady and dnReady being low causes no beat to be lost, duplicated or reordered.
- R10: While a read-lane beat is offered but not accepted, rdUser does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upValid | input | 1 | Upstream packet beat valid |
| upReady | output | 1 | Upstream beat accepted |
| upData | input | 64 | Upstream beat data |
| upKeep | input | 8 | Upstream byte enables |
| upLast | input | 1 | Upstream last beat of packet |
| upId | input | 4 | Upstream packet ID |
| upDest | input | 4 | Upstream destination slave ID |
| dnValid | output | 1 | Downstream beat valid |
| dnReady | input | 1 | Downstream sink ready |
| dnData | output | 64 | Downstream beat data |
| dnKeep | output | 8 | Downstream byte enables |
| dnLast | output | 1 | Downstream last beat |
| dnId | output | 4 | Downstream packet ID (sender) |
| dnDest | output | 4 | Downstream destination ID |
| wrValid | output | 1 | Write lane beat valid |
| wrReady | input | 1 | Write lane ready from slave chain |
| wrData | output | 64 | Write lane data |
| wrKeep | output | 8 | Write lane byte enables |
| wrLast | output | 1 | Write lane last beat |
| wrId | output | 4 | Write lane packet ID |
| wrDest | output | 4 | Write lane destination slave ID |
| wrUser | output | 4 | Write lane origin: MASTER_ID or the sending slave's ID |
| rdValid | input | 1 | Read lane beat valid |
| rdReady | output | 1 | Read lane beat accepted |
| rdData | input | 64 | Read lane data |
| rdKeep | input | 8 | Read lane byte enables |
| rdLast | input | 1 | Read lane last beat |
| rdId | input | 4 | Read lane packet ID (sender) |
| rdDest | input | 4 | Read lane destination ID |
| rdUser | output | 4 | Access token driven by the master |

## Verification
With no traffic on either lane, the bench checks that the token steps through every slave ID and that each slot lasts the right number of cycles, which exercises the skip rule on its own. Each slave then sends one packet to every one of the 16 destination IDs while upstream packets compete for the write lane. This separates the bypass route from the downstream route for the master's own ID, for the slave IDs and for every unknown ID. The same traffic runs first with both sinks always ready and then with pseudo-random backpressure. The first run exposes any latency or ordering fault. The second exposes lost or interleaved beats and a token that moves while a beat waits.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int DATA_W = 64;
  localparam int KEEP_W = DATA_W / 8;
  localparam int TAG_W  = 4;

  typedef enum logic [1:0] {
    OWN_IDLE,
    OWN_UP,
    OWN_BYP
  } wrOwner_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrFromUp;
    logic             wrFromByp;
    logic             rdToWr;
    logic             rdToDn;
    logic [TAG_W-1:0] token;
  } laneCtl_t;
endpackage

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int FIRST_SLAVE = 2,
  parameter int NUM_SLAVES  = 4,
  parameter int SLOT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upValid,
  input  logic             upLast,
  input  logic             rdValid,
  input  logic             rdLast,
  input  logic [TAG_W-1:0] rdDest,
  input  logic             wrReady,
  input  logic             dnReady,
  output laneCtl_t         ctl
);
  localparam int LAST_SLAVE = FIRST_SLAVE + NUM_SLAVES - 1;
  localparam logic [TAG_W-1:0] FIRST_TAG = TAG_W'(FIRST_SLAVE);
  localparam logic [TAG_W-1:0] LAST_TAG  = TAG_W'(LAST_SLAVE);
  localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(SLOT_CYCLES - 1);

  wrOwner_e         ownerQ, ownerNow;
  logic             rdBusyQ, rdBypQ;
  logic [TAG_W-1:0] tokenQ, tokenNext;
  logic [CNT_W-1:0] slotQ;

  logic destLocal, rdByp;
  logic wrValidEff, wrLastEff, wrFire, rdFire;
  logic slotEnd, tokenAdvance;

  // route of the read packet: fixed at its first beat
  assign destLocal = (rdDest >= FIRST_TAG) && (rdDest <= LAST_TAG);
  assign rdByp     = rdBusyQ ? rdBypQ : destLocal;

  // write lane owner; a waiting bypass head wins over upstream
  always_comb begin
    ownerNow = ownerQ;
    if (ownerQ == OWN_IDLE) begin
      if (rdValid && rdByp)  ownerNow = OWN_BYP;
      else if (upValid)      ownerNow = OWN_UP;
    end
  end

  assign ctl.wrFromUp  = (ownerNow == OWN_UP);
  assign ctl.wrFromByp = (ownerNow == OWN_BYP);
  assign ctl.rdToWr    = rdByp && (ownerNow == OWN_BYP);
  assign ctl.rdToDn    = !rdByp;
  assign ctl.token     = tokenQ;

  assign wrValidEff = ctl.wrFromUp ? upValid : (ctl.wrFromByp ? rdValid : 1'b0);
  assign wrLastEff  = ctl.wrFromUp ? upLast : rdLast;
  assign wrFire     = wrValidEff && wrReady;
  assign rdFire     = rdValid && (ctl.rdToWr ? wrReady : (ctl.rdToDn ? dnReady : 1'b0));

  assign slotEnd      = !rdBusyQ && !rdValid && (slotQ == SLOT_END);
  assign tokenAdvance = (rdFire && rdLast) || slotEnd;
  assign tokenNext    = (tokenQ == LAST_TAG) ? FIRST_TAG : tokenQ + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ownerQ  <= OWN_IDLE;
      rdBusyQ <= 1'b0;
      rdBypQ  <= 1'b0;
      tokenQ  <= FIRST_TAG;
      slotQ   <= '0;
    end else begin
      if (wrFire) ownerQ <= wrLastEff ? OWN_IDLE : ownerNow;
      if (rdFire) begin
        rdBusyQ <= !rdLast;
        rdBypQ  <= rdByp;
      end
      if (tokenAdvance) begin
        tokenQ <= tokenNext;
        slotQ  <= '0;
      end else if (rdBusyQ || rdValid) begin
        slotQ  <= '0;
      end else begin
        slotQ  <= slotQ + 1'b1;
      end
    end
  end

  AST_TOKEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (tokenQ >= FIRST_TAG) && (tokenQ <= LAST_TAG)); // R4

  AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tokenQ != $past(tokenQ)) |->
      (tokenQ == (($past(tokenQ) == LAST_TAG) ? FIRST_TAG : $past(tokenQ) + 1'b1))); // R4

  AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdValid && !rdFire) |=> $stable(tokenQ)); // R10

  AST_WR_LOCK: assert property (@(posedge clk) disable iff (rst)
    (wrFire && !wrLastEff && ctl.wrFromUp) |=> ctl.wrFromUp); // R8

  AST_RD_ROUTE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (rdFire && !rdLast) |=> $stable(ctl.rdToDn)); // R8
endmodule

// File: rtl/sbm_dp.sv
module sbm_dp
  import sbm_pkg::*;
#(
  parameter int MASTER_ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  laneCtl_t          ctl,
  input  logic              upValid,
  output logic              upReady,
  input  logic [DATA_W-1:0] upData,
  input  logic [KEEP_W-1:0] upKeep,
  input  logic              upLast,
  input  logic [TAG_W-1:0]  upId,
  input  logic [TAG_W-1:0]  upDest,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [DATA_W-1:0] dnData,
  output logic [KEEP_W-1:0] dnKeep,
  output logic              dnLast,
  output logic [TAG_W-1:0]  dnId,
  output logic [TAG_W-1:0]  dnDest,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [DATA_W-1:0] wrData,
  output logic [KEEP_W-1:0] wrKeep,
  output logic              wrLast,
  output logic [TAG_W-1:0]  wrId,
  output logic [TAG_W-1:0]  wrDest,
  output logic [TAG_W-1:0]  wrUser,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [DATA_W-1:0] rdData,
  input  logic [KEEP_W-1:0] rdKeep,
  input  logic              rdLast,
  input  logic [TAG_W-1:0]  rdId,
  input  logic [TAG_W-1:0]  rdDest,
  output logic [TAG_W-1:0]  rdUser
);
  localparam logic [TAG_W-1:0] MASTER_TAG = TAG_W'(MASTER_ID);

  // write lane source mux
  assign wrValid = ctl.wrFromUp ? upValid : (ctl.wrFromByp ? rdValid : 1'b0);
  assign wrData  = ctl.wrFromByp ? rdData : upData;
  assign wrKeep  = ctl.wrFromByp ? rdKeep : upKeep;
  assign wrLast  = ctl.wrFromByp ? rdLast : upLast;
  assign wrId    = ctl.wrFromByp ? rdId   : upId;
  assign wrDest  = ctl.wrFromByp ? rdDest : upDest;
  assign wrUser  = ctl.wrFromByp ? ctl.token : MASTER_TAG;
  assign upReady = ctl.wrFromUp && wrReady;

  // read lane split: bypass or downstream
  assign rdReady = ctl.rdToWr ? wrReady : (ctl.rdToDn ? dnReady : 1'b0);
  assign rdUser  = ctl.token;
  assign dnValid = rdValid && ctl.rdToDn;
  assign dnData  = rdData;
  assign dnKeep  = rdKeep;
  assign dnLast  = rdLast;
  assign dnId    = rdId;
  assign dnDest  = rdDest;

  AST_ONE_WR_SRC: assert property (@(posedge clk) disable iff (rst)
    !(upReady && rdReady && ctl.rdToWr)); // R8

  AST_DN_NOT_LOCAL: assert property (@(posedge clk) disable iff (rst)
    !(dnValid && ctl.rdToWr)); // R6
endmodule

// File: rtl/stream_bus_master.sv
module stream_bus_master
  import sbm_pkg::*;
#(
  parameter int MASTER_ID   = 1,
  parameter int FIRST_SLAVE = 2,
  parameter int NUM_SLAVES  = 4,
  parameter int SLOT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upValid,
  output logic              upReady,
  input  logic [DATA_W-1:0] upData,
  input  logic [KEEP_W-1:0] upKeep,
  input  logic              upLast,
  input  logic [TAG_W-1:0]  upId,
  input  logic [TAG_W-1:0]  upDest,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [DATA_W-1:0] dnData,
  output logic [KEEP_W-1:0] dnKeep,
  output logic              dnLast,
  output logic [TAG_W-1:0]  dnId,
  output logic [TAG_W-1:0]  dnDest,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [DATA_W-1:0] wrData,
  output logic [KEEP_W-1:0] wrKeep,
  output logic              wrLast,
  output logic [TAG_W-1:0]  wrId,
  output logic [TAG_W-1:0]  wrDest,
  output logic [TAG_W-1:0]  wrUser,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [DATA_W-1:0] rdData,
  input  logic [KEEP_W-1:0] rdKeep,
  input  logic              rdLast,
  input  logic [TAG_W-1:0]  rdId,
  input  logic [TAG_W-1:0]  rdDest,
  output logic [TAG_W-1:0]  rdUser
);
  laneCtl_t ctl;

  sbm_ctrl #(
    .FIRST_SLAVE(FIRST_SLAVE),
    .NUM_SLAVES (NUM_SLAVES),
    .SLOT_CYCLES(SLOT_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .upValid(upValid),
    .upLast (upLast),
    .rdValid(rdValid),
    .rdLast (rdLast),
    .rdDest (rdDest),
    .wrReady(wrReady),
    .dnReady(dnReady),
    .ctl    (ctl)
  );

  sbm_dp #(
    .MASTER_ID(MASTER_ID)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .upValid(upValid), .upReady(upReady), .upData(upData), .upKeep(upKeep),
    .upLast (upLast),  .upId(upId),       .upDest(upDest),
    .dnValid(dnValid), .dnReady(dnReady), .dnData(dnData), .dnKeep(dnKeep),
    .dnLast (dnLast),  .dnId(dnId),       .dnDest(dnDest),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData), .wrKeep(wrKeep),
    .wrLast (wrLast),  .wrId(wrId),       .wrDest(wrDest), .wrUser(wrUser),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData), .rdKeep(rdKeep),
    .rdLast (rdLast),  .rdId(rdId),       .rdDest(rdDest), .rdUser(rdUser)
  );
endmodule

// File: tb/test_stream_bus_master.sv
module test_stream_bus_master;
  localparam int CLK_P = 10;
  localparam int MID   = 1;
  localparam int FS    = 2;
  localparam int NS    = 4;
  localparam int LS    = FS + NS - 1;
  localparam int SLOT  = 4;
  localparam int NUP   = 24;
  localparam int NPK   = 16;
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst = 1'b1;
  logic upValid = 0, upReady, upLast = 0;
  logic [63:0] upData = '0;
  logic [7:0] upKeep = '0;
  logic [3:0] upId = '0, upDest = '0;
  logic dnValid, dnReady = 0, dnLast;
  logic [63:0] dnData;
  logic [7:0] dnKeep;
  logic [3:0] dnId, dnDest;
  logic wrValid, wrReady = 0, wrLast;
  logic [63:0] wrData;
  logic [7:0] wrKeep;
  logic [3:0] wrId, wrDest, wrUser;
  logic rdValid = 0, rdReady, rdLast = 0;
  logic [63:0] rdData = '0;
  logic [7:0] rdKeep = '0;
  logic [3:0] rdId = '0, rdDest = '0, rdUser;

  int nChk = 0, nBad = 0;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  stream_bus_master #(.MASTER_ID(MID), .FIRST_SLAVE(FS), .NUM_SLAVES(NS), .SLOT_CYCLES(SLOT))
  i_stream_bus_master (
    .clk(clk), .rst(rst),
    .upValid(upValid), .upReady(upReady), .upData(upData), .upKeep(upKeep),
    .upLast(upLast), .upId(upId), .upDest(upDest),
    .dnValid(dnValid), .dnReady(dnReady), .dnData(dnData), .dnKeep(dnKeep),
    .dnLast(dnLast), .dnId(dnId), .dnDest(dnDest),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData), .wrKeep(wrKeep),
    .wrLast(wrLast), .wrId(wrId), .wrDest(wrDest), .wrUser(wrUser),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData), .rdKeep(rdKeep),
    .rdLast(rdLast), .rdId(rdId), .rdDest(rdDest), .rdUser(rdUser)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit isLocal(int d);
    return (d >= FS) && (d <= LS);
  endfunction
  function automatic int nextLocal(int k);
    int r = k;
    while (r < NPK && !isLocal(r)) r++;
    return r;
  endfunction
  function automatic int nextRemote(int k);
    int r = k;
    while (r < NPK && isLocal(r)) r++;
    return r;
  endfunction

  // slave packet k of slave s is addressed to dest k
  function automatic int sLen(int s, int k); return 1 + ((s + k) % 3); endfunction
  function automatic logic [63:0] sData(int s, int k, int j);
    return {4'(s), 4'(k), 8'(j), 48'(s * 4096 + k * 64 + j)};
  endfunction
  function automatic logic [7:0] sKeep(int s, int k, int j);
    return (j == sLen(s, k) - 1) ? (8'hFF >> (k % 8)) : 8'hFF;
  endfunction
  function automatic int uLen(int p); return 1 + (p % 4); endfunction
  function automatic logic [63:0] uData(int p, int j);
    return {16'hC0DE, 8'(p), 8'(j), 32'(p * 97 + j * 13)};
  endfunction
  function automatic logic [7:0] uKeep(int p, int j);
    return (j == uLen(p) - 1) ? (8'hFF >> (p % 8)) : 8'hFF;
  endfunction
  function automatic logic [3:0] uDest(int p); return 4'((p * 5) % 16); endfunction

  task automatic tokenSweep();
    int lastTok = -1, lastCyc = 0, changes = 0;
    for (int c = 0; c < 60; c++) begin
      @(posedge clk); #1; #2;
      if (c == 0) check(rdUser == 4'(FS), "R1", "token after reset", rdUser, FS);
      if (lastTok >= 0 && int'(rdUser) != lastTok) begin
        check(int'(rdUser) == ((lastTok == LS) ? FS : lastTok + 1), "R5", "token successor", rdUser,
              (lastTok == LS) ? FS : lastTok + 1);
        if (changes > 0) check(c - lastCyc == SLOT, "R5", "slot length", c - lastCyc, SLOT);
        changes++;
        lastCyc = c;
      end
      lastTok = int'(rdUser);
    end
    check(changes >= 8, "R5", "token changes when idle", changes, 8);
  endtask

  task automatic runTraffic(input int mode);
    int upP = 0, upB = 0, eUpP = 0, eUpB = 0, sndS = -1, wrSrc = -1, concur = 0;
    int txK[16], txB[16], ebK[16], ebB[16], edK[16], edB[16];
    bit upAct = 0, done = 0;
    int cyc = 0;
    string rq = (mode == 0) ? "" : "/R9";
    for (int s = 0; s < 16; s++) begin
      txK[s] = 0; txB[s] = 0; ebB[s] = 0; edB[s] = 0;
      ebK[s] = nextLocal(0); edK[s] = nextRemote(0);
    end
    while (!done && cyc < LIMIT) begin
      bit wrF, rdF, upF, dnF;
      @(posedge clk); #1;
      cyc++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wrReady = (mode == 0) ? 1'b1 : (lf[0] | lf[3]);
      dnReady = (mode == 0) ? 1'b1 : (lf[1] | lf[5]);
      if (!upAct && upP < NUP && (mode == 0 || lf[2] || lf[4])) upAct = 1;
      upValid = upAct;
      if (upP < NUP) begin
        upData = uData(upP, upB); upKeep = uKeep(upP, upB);
        upLast = (upB == uLen(upP) - 1); upId = 4'(upP % 16); upDest = uDest(upP);
      end
      if (sndS < 0 && isLocal(int'(rdUser)) && txK[rdUser] < NPK) sndS = int'(rdUser);
      rdValid = (sndS >= 0);
      if (sndS >= 0) begin
        rdData = sData(sndS, txK[sndS], txB[sndS]); rdKeep = sKeep(sndS, txK[sndS], txB[sndS]);
        rdLast = (txB[sndS] == sLen(sndS, txK[sndS]) - 1);
        rdId = 4'(sndS); rdDest = 4'(txK[sndS]);
      end
      #2;
      wrF = wrValid && wrReady; rdF = rdValid && rdReady;
      upF = upValid && upReady; dnF = dnValid && dnReady;
      if (rdValid) check(int'(rdUser) == sndS, {"R4/R10", rq}, "token vs sender", rdUser, sndS);
      if (wrF) begin
        if (wrSrc >= 0) check(int'(wrUser) == wrSrc, "R8", "write lane interleave", wrUser, wrSrc);
        wrSrc = wrLast ? -1 : int'(wrUser);
        if (wrUser == 4'(MID)) begin
          check(eUpP < NUP, {"R2", rq}, "extra upstream beat", eUpP, NUP);
          if (eUpP < NUP) begin
            check(wrData == uData(eUpP, eUpB) && wrKeep == uKeep(eUpP, eUpB) &&
                  wrLast == (eUpB == uLen(eUpP) - 1) && wrId == 4'(eUpP % 16) &&
                  wrDest == uDest(eUpP), {"R2", rq}, "upstream beat", wrData, uData(eUpP, eUpB));
            eUpB++;
            if (eUpB == uLen(eUpP)) begin eUpB = 0; eUpP++; end
          end
        end else begin
          int s = int'(wrUser);
          check(rdF && wrData == rdData, {"R6", rq}, "bypass same cycle", wrData, rdData);
          check(isLocal(s) && ebK[s] < NPK, "R6", "bypass sender", s, sndS);
          if (isLocal(s) && ebK[s] < NPK) begin
            check(wrData == sData(s, ebK[s], ebB[s]) && wrKeep == sKeep(s, ebK[s], ebB[s]) &&
                  wrDest == 4'(ebK[s]) && wrId == 4'(s) &&
                  wrLast == (ebB[s] == sLen(s, ebK[s]) - 1), {"R6", rq}, "bypass beat",
                  wrData, sData(s, ebK[s], ebB[s]));
            ebB[s]++;
            if (ebB[s] == sLen(s, ebK[s])) begin ebB[s] = 0; ebK[s] = nextLocal(ebK[s] + 1); end
          end
        end
      end
      if (dnF) begin
        int s = int'(dnId);
        check(!isLocal(int'(dnDest)), "R7", "local dest on downstream", dnDest, 0);
        check(isLocal(s) && edK[s] < NPK, "R7", "downstream sender", s, sndS);
        if (isLocal(s) && edK[s] < NPK) begin
          check(dnData == sData(s, edK[s], edB[s]) && dnKeep == sKeep(s, edK[s], edB[s]) &&
                dnDest == 4'(edK[s]) && dnLast == (edB[s] == sLen(s, edK[s]) - 1),
                {"R7", rq}, "downstream beat", dnData, sData(s, edK[s], edB[s]));
          edB[s]++;
          if (edB[s] == sLen(s, edK[s])) begin edB[s] = 0; edK[s] = nextRemote(edK[s] + 1); end
        end
      end
      if (upF && dnF) concur++;
      if (upF) begin
        upAct = 0; upB++;
        if (upB == uLen(upP)) begin upB = 0; upP++; end
      end
      if (rdF) begin
        txB[sndS]++;
        if (txB[sndS] == sLen(sndS, txK[sndS])) begin txB[sndS] = 0; txK[sndS]++; sndS = -1; end
      end
      done = (upP == NUP) && (eUpP == NUP);
      for (int s = FS; s <= LS; s++)
        if (txK[s] < NPK || ebK[s] < NPK || edK[s] < NPK) done = 0;
    end
    if (!done) check(0, "R9", "traffic watchdog", cyc, LIMIT);
    check(concur > 0, "R3", "concurrent lanes", concur, 1);
    @(posedge clk); #1;
    upValid = 0; rdValid = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "R9", "global watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    #3;
    check(wrValid == 0, "R1", "wrValid in reset", wrValid, 0);
    check(dnValid == 0, "R1", "dnValid in reset", dnValid, 0);
    check(rdUser == 4'(FS), "R1", "token in reset", rdUser, FS);
    @(posedge clk); #1;
    rst = 0;
    tokenSweep();
    runTraffic(0);
    runTraffic(1);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule